// File: doc/BRIEF.md
# Integer Accumulator ALU Stage

This block is the integer execution stage of a small 32-bit DSP datapath. It keeps four working registers, here called A, B, C and D. On every clock where a strobe marks the 6-bit operation code as valid, it carries out one integer operation and writes the result into a fixed destination register.

The low bit of the code picks the partner register, C or D. That register is either the accumulator that receives the result or the source of a shift count. The operations are:

- bitwise AND with A;
- 24-bit add and subtract of A;
- logical left and right shifts of A.

Only the subtract updates the zero, negative and carry flags. Every other code, including the floating-point ones handled elsewhere, leaves all state alone.

A direct load port writes any register. It is used to seed operands and for test.

Top module: `ialu_stage`

## Requirements
- R1: While `rst_n` is low, all four registers and the three flags read zero.
- R2: With `ld_en` high, `ld_data` is written on the next rising edge into the register picked by `ld_sel` (0 = A, 1 = B, 2 = C, 3 = D). In that cycle the operation input is ignored.
- R3: Codes 0x00 and 0x01, and any cycle with `op_valid` low, change no register and no flag.
- R4: Codes 0x02 and 0x03 write C & A into C, or D & A into D, over the full 32 bits.
- R5: Codes 0x34 and 0x35 add A[23:0] to C[23:0] or D[23:0]. The low 24 bits of the sum are written to bits 23:0 of the destination, and bits 31:24 are cleared.
- R6: Codes 0x36 and 0x37 subtract A[23:0] from C[23:0] or D[23:0], writing the result the same way as R5. They set three flags: zero when the 24-bit result is 0; negative from result bit 23; carry from bit 24 of the 25-bit difference, which is 1 when a borrow occurs.
- R7: Codes 0x2E and 0x2F shift A left by C[4:0] or D[4:0], filling with zeros.
- R8: Codes 0x30 and 0x31 shift A right logically by C[4:0] or D[4:0].
- R9: Every other code changes no register and no flag. Register B is changed only through the load port.
- R10: The flags hold their value on every cycle other than a valid subtract.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| op_valid | input | 1 | Operation code is valid this cycle |
| op_code | input | 6 | ALU operation code |
| ld_en | input | 1 | Direct register load strobe |
| ld_sel | input | 2 | Load target: 0 A, 1 B, 2 C, 3 D |
| ld_data | input | 32 | Load value |
| reg_a | output | 32 | Register A |
| reg_b | output | 32 | Register B |
| reg_c | output | 32 | Register C |
| reg_d | output | 32 | Register D |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry / borrow flag |

## Verification
The corners that are hardest to reach from the ports are a subtract with an exactly zero difference, and a shift whose count register has bits set above bit 4, so that only the low five bits count. Both need exact operand values in the registers beforehand.

The stimulus first writes those operands through the load port, then issues the operation. It also presents a load and an operation in the same cycle, to show that the load wins. A long mixed run then sweeps all 64 codes between random loads, and a reference model is compared with every register and flag after every edge.

// File: rtl/ialu_pkg.sv
package ialu_pkg;
  localparam int unsigned OPW = 6;
  localparam int unsigned NREG = 4;
  localparam int unsigned SELW = 2;

  localparam logic [SELW-1:0] IDX_A = 2'd0;
  localparam logic [SELW-1:0] IDX_B = 2'd1;
  localparam logic [SELW-1:0] IDX_C = 2'd2;
  localparam logic [SELW-1:0] IDX_D = 2'd3;

  // upper five bits of the code; bit 0 chooses C (0) or D (1)
  localparam logic [OPW-2:0] GRP_NOP = 5'h00;
  localparam logic [OPW-2:0] GRP_AND = 5'h01;
  localparam logic [OPW-2:0] GRP_SHL = 5'h17;
  localparam logic [OPW-2:0] GRP_SHR = 5'h18;
  localparam logic [OPW-2:0] GRP_ADD = 5'h1A;
  localparam logic [OPW-2:0] GRP_SUB = 5'h1B;

  typedef enum logic [2:0] {
    K_NOP, K_AND, K_ADD, K_SUB, K_SHL, K_SHR
  } kind_e;

  typedef struct packed {
    kind_e kind;
    logic  alt;   // 1: partner register is D
  } dec_t;
endpackage

// File: rtl/ialu_rst_sync.sv
module ialu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q    <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      s1_q    <= 1'b1;
      rst_q_n <= s1_q;
    end
  end
endmodule

// File: rtl/ialu_decode.sv
module ialu_decode
  import ialu_pkg::*;
(
  input  logic [OPW-1:0] op,
  output dec_t           dec
);
  always_comb begin
    dec.alt = op[0];
    unique case (op[OPW-1:1])
      GRP_AND: dec.kind = K_AND;
      GRP_ADD: dec.kind = K_ADD;
      GRP_SUB: dec.kind = K_SUB;
      GRP_SHL: dec.kind = K_SHL;
      GRP_SHR: dec.kind = K_SHR;
      default: dec.kind = K_NOP;
    endcase
  end
endmodule

// File: rtl/ialu_exec.sv
module ialu_exec
  import ialu_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 24
) (
  input  dec_t          dec,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] c_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] res,
  output logic          wr_a,
  output logic          wr_acc,
  output logic          flag_we,
  output logic          z_o,
  output logic          n_o,
  output logic          cy_o
);
  localparam int unsigned SHW = $clog2(DW);
  localparam int unsigned HW  = DW - NW;

  logic [DW-1:0]  acc;
  logic [SHW-1:0] shamt;
  logic [NW:0]    sum;
  logic [NW:0]    dif;

  always_comb begin
    acc   = dec.alt ? d_i : c_i;
    shamt = acc[SHW-1:0];
    sum   = {1'b0, acc[NW-1:0]} + {1'b0, a_i[NW-1:0]};
    dif   = {1'b0, acc[NW-1:0]} - {1'b0, a_i[NW-1:0]};
  end

  always_comb begin
    res     = '0;
    wr_a    = 1'b0;
    wr_acc  = 1'b0;
    flag_we = 1'b0;
    unique case (dec.kind)
      K_AND: begin res = acc & a_i;                  wr_acc = 1'b1; end
      K_ADD: begin res = {{HW{1'b0}}, sum[NW-1:0]};  wr_acc = 1'b1; end
      K_SUB: begin
        res     = {{HW{1'b0}}, dif[NW-1:0]};
        wr_acc  = 1'b1;
        flag_we = 1'b1;
      end
      K_SHL: begin res = a_i << shamt; wr_a = 1'b1; end
      K_SHR: begin res = a_i >> shamt; wr_a = 1'b1; end
      default: ;
    endcase
  end

  assign z_o  = (dif[NW-1:0] == '0);
  assign n_o  = dif[NW-1];
  assign cy_o = dif[NW];
endmodule

// File: rtl/ialu_stage.sv
module ialu_stage
  import ialu_pkg::*;
#(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 24
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [5:0]     op_code,
  input  logic           ld_en,
  input  logic [1:0]     ld_sel,
  input  logic [DW-1:0]  ld_data,
  output logic [DW-1:0]  reg_a,
  output logic [DW-1:0]  reg_b,
  output logic [DW-1:0]  reg_c,
  output logic [DW-1:0]  reg_d,
  output logic           flag_z,
  output logic           flag_n,
  output logic           flag_c
);
  localparam int unsigned SHW = $clog2(DW);

  logic           rst_i_n;
  dec_t           dec;
  logic [DW-1:0]  res;
  logic           wr_a, wr_acc, flag_we, z_n, n_n, c_n;
  logic           op_go;
  logic [DW-1:0]  regs_q   [NREG];
  logic [DW-1:0]  regs_nxt [NREG];
  logic           regs_en  [NREG];
  logic           flg_en;

  ialu_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_i_n));

  ialu_decode u_dec (.op(op_code), .dec(dec));

  ialu_exec #(.DW(DW), .NW(NW)) u_exe (
    .dec(dec), .a_i(regs_q[IDX_A]), .c_i(regs_q[IDX_C]), .d_i(regs_q[IDX_D]),
    .res(res), .wr_a(wr_a), .wr_acc(wr_acc), .flag_we(flag_we),
    .z_o(z_n), .n_o(n_n), .cy_o(c_n)
  );

  assign op_go = op_valid && !ld_en;

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic op_hit;
    always_comb begin
      if (gi == IDX_A)      op_hit = wr_a;
      else if (gi == IDX_C) op_hit = wr_acc && !dec.alt;
      else if (gi == IDX_D) op_hit = wr_acc &&  dec.alt;
      else                  op_hit = 1'b0;
      regs_en[gi]  = (ld_en && (ld_sel == gi[SELW-1:0])) || (op_go && op_hit);
      regs_nxt[gi] = ld_en ? ld_data : res;
    end

    always_ff @(posedge clk or negedge rst_i_n) begin
      if (!rst_i_n)         regs_q[gi] <= '0;
      else if (regs_en[gi]) regs_q[gi] <= regs_nxt[gi];
    end
  end

  assign flg_en = op_go && flag_we;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      flag_z <= 1'b0;
      flag_n <= 1'b0;
      flag_c <= 1'b0;
    end else if (flg_en) begin
      flag_z <= z_n;
      flag_n <= n_n;
      flag_c <= c_n;
    end
  end

  assign reg_a = regs_q[IDX_A];
  assign reg_b = regs_q[IDX_B];
  assign reg_c = regs_q[IDX_C];
  assign reg_d = regs_q[IDX_D];

  // load lands in the selected register
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_i_n)
    ld_en |=> (regs_q[$past(ld_sel)] == $past(ld_data)));

  // flags only move on a valid subtract
  assert_flags_hold_R10: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(op_go && op_code[5:1] == GRP_SUB) |=> $stable({flag_z, flag_n, flag_c}));

  assert_add_upper_R5: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op_go && op_code[5:1] == GRP_ADD) |=>
      (($past(op_code[0]) ? reg_d[DW-1:NW] : reg_c[DW-1:NW]) == '0));

  assert_shr_c_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op_go && op_code == 6'h30) |=> (reg_a == ($past(reg_a) >> $past(reg_c[SHW-1:0]))));

  assert_b_only_load_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !(ld_en && ld_sel == IDX_B) |=> $stable(reg_b));

  assert_sub_equal_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    (op_go && op_code == 6'h36 && reg_c[NW-1:0] == reg_a[NW-1:0]) |=> (flag_z && !flag_c && !flag_n));
endmodule

// File: tb/sim_ialu_stage.sv
module sim_ialu_stage;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [5:0]  op_code;
  logic        ld_en;
  logic [1:0]  ld_sel;
  logic [31:0] ld_data;
  logic [31:0] reg_a, reg_b, reg_c, reg_d;
  logic        flag_z, flag_n, flag_c;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] m [4];
  logic        mz, mn, mc;

  always #2 clk = ~clk;

  ialu_stage u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .reg_a(reg_a), .reg_b(reg_b), .reg_c(reg_c), .reg_d(reg_d),
    .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
  );

  task automatic chk32(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    string ft;
    ft = (tag == "R6" || tag == "R1") ? tag : "R10";
    chk32(tag, "reg_a", reg_a, m[0]);
    chk32((tag == "R2" || tag == "R1") ? tag : "R9", "reg_b", reg_b, m[1]);
    chk32(tag, "reg_c", reg_c, m[2]);
    chk32(tag, "reg_d", reg_d, m[3]);
    chk1(ft, "flag_z", flag_z, mz);
    chk1(ft, "flag_n", flag_n, mn);
    chk1(ft, "flag_c", flag_c, mc);
  endtask

  function automatic string tag_of(input bit v, input bit [5:0] op, input bit le);
    if (le) return "R2";
    if (!v || op < 6'h02) return "R3";
    case (op)
      6'h02, 6'h03: return "R4";
      6'h34, 6'h35: return "R5";
      6'h36, 6'h37: return "R6";
      6'h2E, 6'h2F: return "R7";
      6'h30, 6'h31: return "R8";
      default:      return "R9";
    endcase
  endfunction

  // behavioural reference for one clock edge
  task automatic model(input bit v, input bit [5:0] op, input bit le, input bit [1:0] ls, input bit [31:0] ld);
    int unsigned x, acc, k;
    int          dst;
    if (le) begin
      m[ls] = ld;
      return;
    end
    if (!v) return;
    dst = op[0] ? 3 : 2;
    acc = m[dst];
    x   = m[0];
    k   = acc % 32;
    case (op)
      6'h02, 6'h03: m[dst] = acc & x;
      6'h34, 6'h35: m[dst] = ((acc % 32'h0100_0000) + (x % 32'h0100_0000)) % 32'h0100_0000;
      6'h36, 6'h37: begin
        int signed dd;
        dd = int'(acc % 32'h0100_0000) - int'(x % 32'h0100_0000);
        mc = (dd < 0);
        if (dd < 0) dd = dd + 32'h0100_0000;
        m[dst] = dd;
        mz = (dd == 0);
        mn = (dd >= 32'h0080_0000);
      end
      6'h2E, 6'h2F: m[0] = x << k;
      6'h30, 6'h31: m[0] = x >> k;
      default: ;
    endcase
  endtask

  task automatic step(input bit v, input bit [5:0] op, input bit le, input bit [1:0] ls, input bit [31:0] ld);
    op_valid = v; op_code = op; ld_en = le; ld_sel = ls; ld_data = ld;
    @(posedge clk);
    model(v, op, le, ls, ld);
    @(negedge clk);
    compare_all(tag_of(v, op, le));
  endtask

  task automatic load(input bit [1:0] ls, input bit [31:0] ld);
    step(1'b0, 6'h00, 1'b1, ls, ld);
  endtask

  task automatic exec(input bit [5:0] op);
    step(1'b1, op, 1'b0, 2'd0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m[i] = '0;
    mz = 0; mn = 0; mc = 0;
    rst_n = 0; op_valid = 0; op_code = 0; ld_en = 0; ld_sel = 0; ld_data = 0;
    repeat (3) @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    repeat (4) @(negedge clk);
    compare_all("R1");

    // R2 loads
    load(2'd0, 32'h00F0_F00F);
    load(2'd1, 32'hDEAD_BEEF);
    load(2'd2, 32'hFFFF_FF0F);
    load(2'd3, 32'h1234_5678);
    // R4 AND
    exec(6'h02);
    exec(6'h03);
    // R3 no-ops and invalid strobe
    exec(6'h00);
    exec(6'h01);
    step(1'b0, 6'h36, 1'b0, 2'd0, 32'h0);
    // R5 add, wrap at 24 bits, upper byte cleared
    load(2'd0, 32'hAB00_0001);
    load(2'd2, 32'h77FF_FFFF);
    exec(6'h34);
    load(2'd3, 32'hFF80_0000);
    exec(6'h35);
    // R6 equal operands -> zero
    load(2'd0, 32'h0012_3456);
    load(2'd2, 32'hFF12_3456);
    exec(6'h36);
    // R6 borrow and negative
    load(2'd3, 32'h0000_0005);
    exec(6'h37);
    // R10 flags hold across add
    exec(6'h35);
    // R7 / R8 shifts with count bits above 4 set
    load(2'd0, 32'h8000_0001);
    load(2'd2, 32'h0000_0024);
    exec(6'h2E);
    load(2'd3, 32'hFFFF_FFFF);
    exec(6'h31);
    exec(6'h30);
    // R9 unlisted codes
    exec(6'h10);
    exec(6'h3F);
    exec(6'h28);
    // R2 load wins over simultaneous operation
    step(1'b1, 6'h2F, 1'b1, 2'd3, 32'h0000_0003);

    // mixed sweep
    for (int n = 0; n < 800; n++) begin
      int r;
      r = $urandom % 10;
      if (r < 3) begin
        bit [31:0] dv;
        dv = ($urandom % 4 == 0) ? ($urandom % 64) : $urandom;
        step($urandom % 2, 6'($urandom), 1'b1, 2'($urandom), dv);
      end else begin
        step(($urandom % 10) != 0, 6'($urandom), 1'b0, 2'd0, 32'h0);
      end
    end

    // R1 reset mid-run
    rst_n = 0;
    for (int i = 0; i < 4; i++) m[i] = '0;
    mz = 0; mn = 0; mc = 0;
    @(posedge clk);
    @(negedge clk);
    compare_all("R1");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule